// File: doc/BRIEF.md
# Lock-Protected Board Control Register Bank

This block is a bank of board control and status registers on a plain 32-bit read/write bus with a 4 KB window, decoded on word offsets. It holds a fixed identification word, an LED register, a lock register, two flag sets and a card status register. Each flag set has its own set and clear addresses. One set is volatile. The other survives a soft reset. A reset-control register accepts writes only while the lock holds a magic key, and an accepted write can raise a one-cycle reset request. A display-control register has read-only bits and drives a 2-bit mux select.

The board variant is taken from bits [27:16] of the identification word, which is a parameter. The variant fixes which reset-control bit fires the request, which display bits are writable, and where the write-protect input appears in the card status. Every access is a single strobed cycle. Read data is registered and appears on the cycle after the access. An access to an undecoded offset raises a one-cycle error flag.

Top module: `sysreg_bank`

## Requirements
- R1: After reset the ID word (offset 0x000) reads the ID_WORD parameter, and LED (0x004), lock (0x008), both flag sets and reset control read 0. LED is fully read/write.
- R2: A lock write (0x008) of data[15:0]==0xA05F stores 0xA05F. Any other write stores data[14:0] with bit 15 cleared. The register reads back zero-extended.
- R3: A write to the volatile flag set address (0x010) ORs the data into the flags. A write to the clear address (0x014) ANDs the flags with the inverted data. Reads of either address return the flags.
- R4: The non-volatile flags use 0x018 (set) and 0x01C (clear) in the same way. A soft_rst pulse clears LED, lock, volatile flags and reset level, returns display control to its initial value, and leaves the non-volatile flags unchanged.
- R5: Reset control (0x020) stores written data only while the lock reads 0xA05F, and only on ID 0x100, 0x178 or 0x182. On ID 0x190 it reads 0 and ignores writes.
- R6: An accepted reset-control write raises reset_req for exactly the next cycle when its trigger bit is 1. The trigger bit is bit 8 on ID 0x100 and bit 2 on ID 0x178 and 0x182.
- R7: Display control (0x024) starts at 0x1F00, or 0 on ID 0x190. On ID 0x100 and 0x140 a write keeps bits 13:8 and replaces the rest, and disp_mux follows bits 1:0. On ID 0x178 and 0x182 a write keeps only bit 7, and disp_mux is 0. On ID 0x190 the register reads 0 and ignores writes.
- R8: 0x02C reads 1 and 0x030 reads 0xFF000000. Offsets 0x040 to 0x07C read 0 and ignore writes. None of these raise bus_bad.
- R9: Card status (0x028) bit 0 follows card_present. write_protect appears in bit 2 on ID 0x100 and 0x140 and in bit 1 otherwise. Both are sampled one cycle behind the inputs.
- R10: An access to any other offset reads 0, changes no register, and raises bus_bad for the following cycle only.
- R11: bus_rdata changes only on the cycle after a read access, and holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high full reset |
| soft_rst | input | 1 | Synchronous soft reset, keeps non-volatile flags |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_bad | output | 1 | One-cycle pulse after an undecoded access |
| card_present | input | 1 | Card presence status |
| write_protect | input | 1 | Card write-protect status |
| reset_req | output | 1 | One-cycle reset request |
| disp_mux | output | 2 | Display format mux select |

## Verification
Three copies of the bank, one each for IDs 0x100, 0x178 and 0x190, receive identical bus traffic. A single reset-control or display write therefore shows the trigger bit and the writable masks differing across variants. Reset-control writes are tried in three ways: locked, unlocked with the bit-8 trigger, and unlocked with the bit-2 trigger. This separates the lock gate from the per-variant trigger choice. Both flag sets are swept through alternating set and clear patterns and compared against an arithmetic model. A soft reset issued with distinct values in both sets shows which state survives. Card input combinations tell the two write-protect bit positions apart.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  localparam logic [15:0] LOCK_KEY   = 16'hA05F;
  localparam logic [31:0] PROC1_WORD = 32'hFF00_0000;

  typedef enum logic [2:0] {
    BK_OLDEST,
    BK_SECOND,
    BK_NEWER,
    BK_QUIET,
    BK_OTHER
  } board_kind_e;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_ID,
    SEL_LED,
    SEL_LOCK,
    SEL_FSET,
    SEL_FCLR,
    SEL_NSET,
    SEL_NCLR,
    SEL_RST,
    SEL_DISP,
    SEL_CARD,
    SEL_PCI,
    SEL_PROC1,
    SEL_ZERO
  } reg_sel_e;

  function automatic board_kind_e kind_of(input logic [31:0] id_word);
    case (id_word[27:16])
      12'h100: return BK_OLDEST;
      12'h140: return BK_SECOND;
      12'h178,
      12'h182: return BK_NEWER;
      12'h190: return BK_QUIET;
      default: return BK_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode #(
  parameter int WORD_W = 10
) (
  input  logic [WORD_W-1:0]     word_idx,
  output sysreg_pkg::reg_sel_e  sel
);
  import sysreg_pkg::*;

  always_comb begin
    case (word_idx)
      WORD_W'(0):  sel = SEL_ID;
      WORD_W'(1):  sel = SEL_LED;
      WORD_W'(2):  sel = SEL_LOCK;
      WORD_W'(4):  sel = SEL_FSET;
      WORD_W'(5):  sel = SEL_FCLR;
      WORD_W'(6):  sel = SEL_NSET;
      WORD_W'(7):  sel = SEL_NCLR;
      WORD_W'(8):  sel = SEL_RST;
      WORD_W'(9):  sel = SEL_DISP;
      WORD_W'(10): sel = SEL_CARD;
      WORD_W'(11): sel = SEL_PCI;
      WORD_W'(12): sel = SEL_PROC1;
      default: begin
        if (word_idx >= WORD_W'(16) && word_idx <= WORD_W'(31))
          sel = SEL_ZERO;
        else
          sel = SEL_NONE;
      end
    endcase
  end

endmodule

// File: rtl/sysreg_setclr.sv
module sysreg_setclr #(
  parameter int W            = 32,
  parameter bit KEEP_ON_SOFT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst || (soft_rst && !KEEP_ON_SOFT))
      q <= '0;
    else if (set_en)
      q <= q | wdata;
    else if (clr_en)
      q <= q & ~wdata;
  end

endmodule

// File: rtl/sysreg_board_ctl.sv
module sysreg_board_ctl #(
  parameter int                      DW   = 32,
  parameter sysreg_pkg::board_kind_e KIND = sysreg_pkg::BK_OTHER
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          unlocked,
  input  logic          rst_we,
  input  logic          disp_we,
  input  logic [DW-1:0] wdata,
  input  logic          card_present,
  input  logic          write_protect,
  output logic [DW-1:0] level_q,
  output logic [DW-1:0] disp_q,
  output logic [DW-1:0] card_q,
  output logic          reset_req,
  output logic [1:0]    disp_mux
);
  import sysreg_pkg::*;

  localparam bit OLD_STYLE = (KIND == BK_OLDEST) || (KIND == BK_SECOND);
  localparam bit RST_WR    = (KIND == BK_OLDEST) || (KIND == BK_NEWER);
  localparam bit DISP_WR   = OLD_STYLE || (KIND == BK_NEWER);
  localparam int TRIG_BIT  = (KIND == BK_OLDEST) ? 8 : 2;
  localparam int WP_BIT    = OLD_STYLE ? 2 : 1;
  localparam logic [DW-1:0] KEEP_MASK =
    OLD_STYLE ? DW'(32'h0000_3F00) : DW'(32'h0000_0080);
  localparam logic [DW-1:0] DISP_INIT =
    (KIND == BK_QUIET) ? '0 : DW'(32'h0000_1F00);

  logic [DW-1:0] card_next;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      level_q   <= '0;
      reset_req <= 1'b0;
      disp_q    <= DISP_INIT;
    end else begin
      reset_req <= 1'b0;
      if (RST_WR && rst_we && unlocked) begin
        level_q   <= wdata;
        reset_req <= wdata[TRIG_BIT];
      end
      if (DISP_WR && disp_we)
        disp_q <= (disp_q & KEEP_MASK) | (wdata & ~KEEP_MASK);
    end
  end

  always_comb begin
    card_next         = '0;
    card_next[0]      = card_present;
    card_next[WP_BIT] = write_protect;
  end

  always_ff @(posedge clk) begin
    if (rst)
      card_q <= '0;
    else
      card_q <= card_next;
  end

  generate
    if (OLD_STYLE) begin : g_mux
      assign disp_mux = disp_q[1:0];
    end else begin : g_nomux
      assign disp_mux = 2'b00;
    end
  endgenerate

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank #(
  parameter logic [31:0] ID_WORD = 32'h0100_0A11,
  parameter int          ADDR_W  = 12,
  parameter int          DW      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_bad,
  input  logic              card_present,
  input  logic              write_protect,
  output logic              reset_req,
  output logic [1:0]        disp_mux
);
  import sysreg_pkg::*;

  localparam int          WORD_W = ADDR_W - 2;
  localparam int          LOCK_W = 16;
  localparam board_kind_e KIND   = kind_of(ID_WORD);

  reg_sel_e            sel;
  logic                we;
  logic [DW-1:0]       led_q;
  logic [LOCK_W-1:0]   lock_q;
  logic [DW-1:0]       fl_q [2];
  logic [DW-1:0]       nv_q;
  logic [1:0]          set_en;
  logic [1:0]          clr_en;
  logic [DW-1:0]       level_q;
  logic [DW-1:0]       disp_q;
  logic [DW-1:0]       card_q;
  logic [DW-1:0]       rd_val;

  sysreg_decode #(.WORD_W(WORD_W)) u_dec (
    .word_idx (bus_addr[ADDR_W-1:2]),
    .sel      (sel)
  );

  assign we     = bus_sel && bus_wr;
  assign set_en = {we && (sel == SEL_NSET), we && (sel == SEL_FSET)};
  assign clr_en = {we && (sel == SEL_NCLR), we && (sel == SEL_FCLR)};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_flags
      sysreg_setclr #(.W(DW), .KEEP_ON_SOFT(g == 1)) u_sc (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .set_en   (set_en[g]),
        .clr_en   (clr_en[g]),
        .wdata    (bus_wdata),
        .q        (fl_q[g])
      );
    end
  endgenerate

  assign nv_q = fl_q[1];

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      led_q  <= '0;
      lock_q <= '0;
    end else begin
      if (we && sel == SEL_LED)
        led_q <= bus_wdata;
      if (we && sel == SEL_LOCK)
        lock_q <= (bus_wdata[LOCK_W-1:0] == LOCK_KEY) ?
                  LOCK_KEY : {1'b0, bus_wdata[LOCK_W-2:0]};
    end
  end

  sysreg_board_ctl #(.DW(DW), .KIND(KIND)) u_board (
    .clk           (clk),
    .rst           (rst),
    .soft_rst      (soft_rst),
    .unlocked      (lock_q == LOCK_KEY),
    .rst_we        (we && sel == SEL_RST),
    .disp_we       (we && sel == SEL_DISP),
    .wdata         (bus_wdata),
    .card_present  (card_present),
    .write_protect (write_protect),
    .level_q       (level_q),
    .disp_q        (disp_q),
    .card_q        (card_q),
    .reset_req     (reset_req),
    .disp_mux      (disp_mux)
  );

  always_comb begin
    case (sel)
      SEL_ID:            rd_val = ID_WORD;
      SEL_LED:           rd_val = led_q;
      SEL_LOCK:          rd_val = DW'(lock_q);
      SEL_FSET, SEL_FCLR: rd_val = fl_q[0];
      SEL_NSET, SEL_NCLR: rd_val = fl_q[1];
      SEL_RST:           rd_val = level_q;
      SEL_DISP:          rd_val = disp_q;
      SEL_CARD:          rd_val = card_q;
      SEL_PCI:           rd_val = DW'(1);
      SEL_PROC1:         rd_val = PROC1_WORD;
      default:           rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_bad   <= 1'b0;
    end else begin
      bus_bad <= bus_sel && (sel == SEL_NONE);
      if (bus_sel && !bus_wr)
        bus_rdata <= rd_val;
    end
  end

endmodule

// File: rtl/sysreg_bank_chk.sv
module sysreg_bank_chk (
  input logic        clk,
  input logic        rst,
  input logic        soft_rst,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic        reset_req,
  input logic        bus_bad,
  input logic [1:0]  disp_mux,
  input logic [15:0] lock_q,
  input logic [31:0] nv_q
);

  // R6: the request never lasts longer than one cycle
  a_r6_req_single: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);

  // R6: a request follows a bus write
  a_r6_req_after_write: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $past(bus_sel && bus_wr));

  // R5: a request only comes from a write made while the key was held
  a_r5_req_needs_key: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $past(lock_q) == 16'hA05F);

  // R10: the error flag only follows an access
  a_r10_bad_after_access: assert property (@(posedge clk) disable iff (rst)
    bus_bad |-> $past(bus_sel));

  // R7: the mux select moves only on a write
  a_r7_mux_hold: assert property (@(posedge clk) disable iff (rst)
    (!soft_rst && !(bus_sel && bus_wr)) |=> $stable(disp_mux));

  // R4: soft reset leaves the non-volatile flags alone
  a_r4_nv_survives: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && !(bus_sel && bus_wr)) |=> $stable(nv_q));

endmodule

bind sysreg_bank sysreg_bank_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .soft_rst  (soft_rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .reset_req (reset_req),
  .bus_bad   (bus_bad),
  .disp_mux  (disp_mux),
  .lock_q    (lock_q),
  .nv_q      (nv_q)
);

// File: tb/sysreg_bank_test.sv
module sysreg_bank_test;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] ID_OLD = 32'h0100_0A11;
  localparam logic [31:0] ID_NEW = 32'h0178_0B22;
  localparam logic [31:0] ID_VX  = 32'h0190_0C33;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        card_present = 1'b0;
  logic        write_protect = 1'b0;

  logic [31:0] rdata [3];
  logic        bad [3];
  logic        req [3];
  logic [1:0]  mux [3];

  int checks = 0;
  int errors = 0;
  logic [31:0] rv [3];
  logic        bv;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysreg_bank #(.ID_WORD(ID_OLD)) uut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata[0]), .bus_bad(bad[0]),
    .card_present(card_present), .write_protect(write_protect),
    .reset_req(req[0]), .disp_mux(mux[0]));

  sysreg_bank #(.ID_WORD(ID_NEW)) uut_new (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata[1]), .bus_bad(bad[1]),
    .card_present(card_present), .write_protect(write_protect),
    .reset_req(req[1]), .disp_mux(mux[1]));

  sysreg_bank #(.ID_WORD(ID_VX)) uut_vx (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata[2]), .bus_bad(bad[2]),
    .card_present(card_present), .write_protect(write_protect),
    .reset_req(req[2]), .disp_mux(mux[2]));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    for (int i = 0; i < 3; i++) rv[i] = rdata[i];
    bv = bad[0];
  endtask

  task automatic chk3(input string tag, input logic [11:0] a,
                      input logic [31:0] e0, input logic [31:0] e1, input logic [31:0] e2);
    rd(a);
    chk({tag, " old"}, rv[0], e0);
    chk({tag, " new"}, rv[1], e1);
    chk({tag, " quiet"}, rv[2], e2);
  endtask

  task automatic chk_req(input string tag, input logic e0, input logic e1, input logic e2);
    chk({tag, " old"}, 32'(req[0]), 32'(e0));
    chk({tag, " new"}, 32'(req[1]), 32'(e1));
    chk({tag, " quiet"}, 32'(req[2]), 32'(e2));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] fm, nm, pat;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk3("R1 id", 12'h000, ID_OLD, ID_NEW, ID_VX);
    chk3("R1 led", 12'h004, 0, 0, 0);
    chk3("R1 lock", 12'h008, 0, 0, 0);
    chk3("R1 flags", 12'h010, 0, 0, 0);
    chk3("R1 nvflags", 12'h018, 0, 0, 0);
    chk3("R1 level", 12'h020, 0, 0, 0);
    chk3("R7 disp init", 12'h024, 32'h1F00, 32'h1F00, 0);

    // R1 LED, R11 read data hold
    wr(12'h004, 32'hDEAD_BEEF);
    chk3("R1 led rw", 12'h004, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    repeat (2) @(negedge clk);
    chk("R11 hold idle", rdata[0], 32'hDEAD_BEEF);
    wr(12'h004, 32'h0000_0001);
    chk("R11 hold write", rdata[0], 32'hDEAD_BEEF);

    // R2 lock
    wr(12'h008, 32'h1234_FFFF);
    chk3("R2 lock other", 12'h008, 32'h7FFF, 32'h7FFF, 32'h7FFF);

    // R5 locked write ignored
    wr(12'h020, 32'h0000_0104);
    chk_req("R5 locked no req", 0, 0, 0);
    chk3("R5 locked level", 12'h020, 0, 0, 0);

    wr(12'h008, 32'h0001_A05F);
    chk3("R2 lock key", 12'h008, 32'hA05F, 32'hA05F, 32'hA05F);

    // R6 bit 8 trigger
    wr(12'h020, 32'h0000_0100);
    chk_req("R6 bit8 req", 1, 0, 0);
    @(negedge clk);
    chk_req("R6 bit8 pulse end", 0, 0, 0);
    chk3("R5 level 100", 12'h020, 32'h100, 32'h100, 0);

    // R6 bit 2 trigger
    wr(12'h020, 32'h0000_0004);
    chk_req("R6 bit2 req", 0, 1, 0);
    @(negedge clk);
    chk_req("R6 bit2 pulse end", 0, 0, 0);
    chk3("R5 level 4", 12'h020, 32'h4, 32'h4, 0);

    // R5 relock
    wr(12'h008, 32'h0000_A05E);
    wr(12'h020, 32'h0000_0104);
    chk_req("R5 relocked no req", 0, 0, 0);
    chk3("R5 relocked level", 12'h020, 32'h4, 32'h4, 0);

    // R7 display masks
    wr(12'h024, 32'hFFFF_FFFF);
    chk("R7 mux old", 32'(mux[0]), 32'h3);
    chk("R7 mux new", 32'(mux[1]), 32'h0);
    chk("R7 mux quiet", 32'(mux[2]), 32'h0);
    chk3("R7 disp ones", 12'h024, 32'hFFFF_DFFF, 32'hFFFF_FF7F, 0);
    wr(12'h024, 32'h0000_0002);
    chk("R7 mux old 2", 32'(mux[0]), 32'h2);
    chk3("R7 disp two", 12'h024, 32'h0000_1F02, 32'h0000_0002, 0);

    // R3 / R4 flag sweeps
    fm = '0; nm = '0;
    for (int k = 0; k < 16; k++) begin
      pat = (32'h1 << (k * 2)) | (32'(k) * 32'h0101_0101);
      if (k % 3 != 2) begin
        wr(12'h010, pat); fm = fm | pat;
      end else begin
        wr(12'h014, pat); fm = fm & ~pat;
      end
      chk3("R3 flags sweep", 12'h010, fm, fm, fm);
      pat = ~pat ^ (32'(k) << 20);
      if (k % 2 == 0) begin
        wr(12'h018, pat); nm = nm | pat;
      end else begin
        wr(12'h01C, pat); nm = nm & ~pat;
      end
      chk3("R4 nv sweep", 12'h01C, nm, nm, nm);
    end
    chk3("R3 clear addr read", 12'h014, fm, fm, fm);

    // R4 soft reset
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk3("R4 soft led", 12'h004, 0, 0, 0);
    chk3("R4 soft lock", 12'h008, 0, 0, 0);
    chk3("R4 soft flags", 12'h010, 0, 0, 0);
    chk3("R4 soft level", 12'h020, 0, 0, 0);
    chk3("R4 soft disp", 12'h024, 32'h1F00, 32'h1F00, 0);
    chk3("R4 soft nv kept", 12'h018, nm, nm, nm);

    // R8 fixed and zero windows
    chk3("R8 pci", 12'h02C, 1, 1, 1);
    chk3("R8 proc1", 12'h030, 32'hFF00_0000, 32'hFF00_0000, 32'hFF00_0000);
    wr(12'h040, 32'hFFFF_FFFF);
    chk3("R8 zero lo", 12'h040, 0, 0, 0);
    chk("R8 no bad", 32'(bv), 0);
    chk3("R8 zero hi", 12'h07C, 0, 0, 0);

    // R9 card status
    card_present = 1'b1; write_protect = 1'b0;
    chk3("R9 present", 12'h028, 1, 1, 1);
    card_present = 1'b0; write_protect = 1'b1;
    chk3("R9 wp", 12'h028, 4, 2, 2);
    card_present = 1'b1;
    chk3("R9 both", 12'h028, 5, 3, 3);

    // R10 undecoded
    wr(12'h004, 32'h0000_5A5A);
    rd(12'h00C);
    chk("R10 bad read data", rv[0], 0);
    chk("R10 bad flag", 32'(bv), 1);
    @(negedge clk);
    chk("R10 bad pulse end", 32'(bad[0]), 0);
    wr(12'h0FC, 32'hFFFF_FFFF);
    chk("R10 bad on write", 32'(bad[0]), 1);
    chk3("R10 led untouched", 12'h004, 32'h5A5A, 32'h5A5A, 32'h5A5A);
    chk("R10 good read no bad", 32'(bv), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule